// File: doc/BRIEF.md
# Speculative Crossbar Switch Allocator with Pessimistic Masking

This block builds the crossbar schedule of a router with P ports in the same cycle as virtual-channel allocation. Each input port can present two kinds of request. A non-speculative request comes from a virtual channel that already holds an output virtual channel. A speculative request comes from a head flit whose virtual-channel allocation is still being decided. Each request is a row of P bits, one per output, and may name several outputs.

Two input-first separable allocators, each built from round-robin arbiters, serve the two request kinds side by side. The speculative result is then filtered without waiting for the non-speculative grants. The filter assumes that every non-speculative request will win. It drops a speculative grant if any non-speculative request exists on the same input row or the same output column. It also drops the grant if virtual-channel allocation failed for that input in the same cycle. The final schedule is the union of the non-speculative grants and the speculative grants that survive. Grants appear combinationally in the cycle of the request. Arbiter priorities advance at the next clock edge, and only for grants that survived.

Top module: `spec_sw_alloc`

## Requirements
- R1: After reset every arbiter gives top priority to index 0, so the lowest requesting index wins. With no requests, `gnt_o` and `spec_o` are all zero. Bit i*P+j of every matrix port means input i and output j.
- R2: A non-speculative grant at (i,j) appears only where `ns_req_i` has bit (i,j) set. Each input and each output receives at most one non-speculative grant.
- R3: A speculative grant on input i is dropped whenever row i of `ns_req_i` has any bit set, even if that request itself names a different output.
- R4: A speculative grant to output j is dropped whenever column j of `ns_req_i` has any bit set. This holds even when that non-speculative request loses its own arbitration.
- R5: A speculative grant on input i is dropped when `vca_ok_i[i]` is 0 in the same cycle.
- R6: `gnt_o` is the union of the non-speculative grants and the surviving speculative grants. It has at most one bit set per row and per column.
- R7: `spec_o` marks exactly the surviving speculative grants. It is a subset of `gnt_o` and of `sp_req_i`.
- R8: An output arbiter that issues a surviving grant moves its top priority to the input after the winner, wrapping from P-1 to 0.
- R9: A speculative grant that is dropped leaves the priorities of both arbiter stages unchanged.
- R10: Grants depend combinationally on the request inputs of the current cycle. There is no register between request and grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ns_req_i | input | P*P | Non-speculative requests, bit i*P+j = input i wants output j |
| sp_req_i | input | P*P | Speculative requests, same encoding |
| vca_ok_i | input | P | Virtual-channel allocation succeeded for input i this cycle |
| gnt_o | output | P*P | Final crossbar schedule |
| spec_o | output | P*P | Grants in `gnt_o` that came from the speculative side |

## Verification
Two things happen in the same cycle: the non-speculative grants are issued and the surviving speculative grants are merged in. This is provoked with request mixes that hit disjoint rows and columns, and with mixes that share an input, share an output, or contain a non-speculative request that loses its own arbitration. The verdict is the exact grant and speculative-flag vectors against values worked out by hand. The second overlap is the pointer update at the edge that follows: a dropped speculative winner must not move priority. This is judged by re-presenting the same requests with success restored and checking that the same input still wins.

// File: rtl/spec_sw_alloc_pkg.sv
package spec_sw_alloc_pkg;
  function automatic int wrap_inc(input int idx, input int n);
    return (idx == n - 1) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/ssa_rr_arb.sv
module ssa_rr_arb
  import spec_sw_alloc_pkg::*;
#(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         upd_i,
  output logic [N-1:0] gnt_o
);
  logic [W-1:0] ptr_q;
  logic [W-1:0] win;
  logic         found;

  always_comb begin
    gnt_o = '0;
    win   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req_i[idx]) begin
        found      = 1'b1;
        gnt_o[idx] = 1'b1;
        win        = W'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (upd_i && found) ptr_q <= W'(wrap_inc(int'(win), N));
  end
endmodule

// File: rtl/ssa_sep_alloc.sv
module ssa_sep_alloc #(
  parameter int P = 4,
  localparam int M = P * P
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [M-1:0] req_i,
  input  logic [M-1:0] keep_i,  // grants that survived, drive pointer updates
  output logic [M-1:0] gnt_o
);
  logic [M-1:0] in_gnt;
  logic [P-1:0] col_req  [P];
  logic [P-1:0] col_gnt  [P];
  logic [P-1:0] col_keep [P];

  for (genvar i = 0; i < P; i++) begin : g_in
    ssa_rr_arb #(.N(P)) u_in_arb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (req_i[i*P +: P]),
      .upd_i (|keep_i[i*P +: P]),
      .gnt_o (in_gnt[i*P +: P])
    );
  end

  always_comb begin
    for (int j = 0; j < P; j++) begin
      for (int i = 0; i < P; i++) begin
        col_req[j][i]  = in_gnt[i*P + j];
        col_keep[j][i] = keep_i[i*P + j];
      end
    end
  end

  for (genvar j = 0; j < P; j++) begin : g_out
    ssa_rr_arb #(.N(P)) u_out_arb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (col_req[j]),
      .upd_i (|col_keep[j]),
      .gnt_o (col_gnt[j])
    );
  end

  always_comb begin
    for (int i = 0; i < P; i++)
      for (int j = 0; j < P; j++)
        gnt_o[i*P + j] = col_gnt[j][i];
  end
endmodule

// File: rtl/spec_sw_alloc.sv
module spec_sw_alloc #(
  parameter int P = 4,
  localparam int M = P * P
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [M-1:0] ns_req_i,
  input  logic [M-1:0] sp_req_i,
  input  logic [P-1:0] vca_ok_i,
  output logic [M-1:0] gnt_o,
  output logic [M-1:0] spec_o
);
  logic [M-1:0] ns_gnt, sp_gnt, sp_keep;
  logic [P-1:0] row_busy, col_busy;

  ssa_sep_alloc #(.P(P)) u_ns_alloc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (ns_req_i),
    .keep_i(ns_gnt),
    .gnt_o (ns_gnt)
  );

  ssa_sep_alloc #(.P(P)) u_sp_alloc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (sp_req_i),
    .keep_i(sp_keep),
    .gnt_o (sp_gnt)
  );

  // pessimistic mask: built from requests, not from grants
  always_comb begin
    row_busy = '0;
    col_busy = '0;
    for (int i = 0; i < P; i++)
      for (int j = 0; j < P; j++)
        if (ns_req_i[i*P + j]) begin
          row_busy[i] = 1'b1;
          col_busy[j] = 1'b1;
        end
  end

  always_comb begin
    for (int i = 0; i < P; i++)
      for (int j = 0; j < P; j++)
        sp_keep[i*P + j] = sp_gnt[i*P + j] & ~row_busy[i] & ~col_busy[j] & vca_ok_i[i];
  end

  assign gnt_o  = ns_gnt | sp_keep;
  assign spec_o = sp_keep;
endmodule

// File: rtl/spec_sw_alloc_chk.sv
module spec_sw_alloc_chk #(
  parameter int P = 4,
  localparam int M = P * P
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [M-1:0] ns_req_i,
  input logic [M-1:0] sp_req_i,
  input logic [P-1:0] vca_ok_i,
  input logic [M-1:0] gnt_o,
  input logic [M-1:0] spec_o
);
  logic [P-1:0] g_row [P];
  logic [P-1:0] g_col [P];
  logic [P-1:0] s_row_any, s_col_any, n_row_any, n_col_any;

  always_comb begin
    s_row_any = '0; s_col_any = '0; n_row_any = '0; n_col_any = '0;
    for (int i = 0; i < P; i++)
      for (int j = 0; j < P; j++) begin
        g_row[i][j] = gnt_o[i*P + j];
        g_col[j][i] = gnt_o[i*P + j];
        if (spec_o[i*P + j])   begin s_row_any[i] = 1'b1; s_col_any[j] = 1'b1; end
        if (ns_req_i[i*P + j]) begin n_row_any[i] = 1'b1; n_col_any[j] = 1'b1; end
      end
  end

  for (genvar k = 0; k < P; k++) begin : g_chk
    AST_ROW_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(g_row[k])); // R6
    AST_COL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(g_col[k])); // R6
    AST_SPEC_ROW_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      n_row_any[k] |-> !s_row_any[k]); // R3
    AST_SPEC_COL_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      n_col_any[k] |-> !s_col_any[k]); // R4
    AST_SPEC_VCA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vca_ok_i[k] |-> !s_row_any[k]); // R5
  end

  AST_SPEC_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((spec_o & ~gnt_o) == '0) && ((spec_o & ~sp_req_i) == '0)); // R7
  AST_NS_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o & ~spec_o & ~ns_req_i) == '0)); // R2
endmodule

bind spec_sw_alloc spec_sw_alloc_chk #(.P(P)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ns_req_i(ns_req_i),
  .sp_req_i(sp_req_i),
  .vca_ok_i(vca_ok_i),
  .gnt_o   (gnt_o),
  .spec_o  (spec_o)
);

// File: tb/spec_sw_alloc_tb.sv
module spec_sw_alloc_tb;
  localparam int P = 4;
  localparam int M = P * P;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [M-1:0] ns_req = '0, sp_req = '0;
  logic [P-1:0] vca_ok = '1;
  logic [M-1:0] gnt, spec;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spec_sw_alloc #(.P(P)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ns_req_i(ns_req), .sp_req_i(sp_req),
    .vca_ok_i(vca_ok), .gnt_o(gnt), .spec_o(spec)
  );

  function automatic logic [M-1:0] b(input int i, input int j);
    logic [M-1:0] v = '0;
    v[i*P + j] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; ns_req = '0; sp_req = '0; vca_ok = '1;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic drive(input logic [M-1:0] n, input logic [M-1:0] s, input logic [P-1:0] v);
    @(negedge clk);
    ns_req = n; sp_req = s; vca_ok = v;
    #1;
  endtask

  task automatic t_reset_idle();
    do_reset();
    drive('0, '0, '1);
    chk("R1 idle gnt", gnt, '0);
    chk("R1 idle spec", spec, '0);
  endtask

  task automatic t_ns_only();
    do_reset();
    drive(b(0,1) | b(2,3), '0, '1);
    chk("R2 ns disjoint", gnt, b(0,1) | b(2,3));
    chk("R7 no spec flag", spec, '0);
  endtask

  task automatic t_spec_only();
    do_reset();
    drive('0, b(1,2), '1);
    chk("R10 spec same cycle", gnt, b(1,2));
    chk("R7 spec flag", spec, b(1,2));
  endtask

  task automatic t_vca_fail();
    do_reset();
    drive('0, b(1,2), 4'b1101);
    chk("R5 vca fail drops", gnt, '0);
  endtask

  task automatic t_row_mask();
    do_reset();
    drive(b(0,1), b(0,2), '1);
    chk("R3 row mask", gnt, b(0,1));
    chk("R3 row mask spec", spec, '0);
  endtask

  task automatic t_col_mask();
    do_reset();
    drive(b(1,3), b(2,3), '1);
    chk("R4 col mask", gnt, b(1,3));
  endtask

  task automatic t_pessimism();
    do_reset();
    // in2's ns request loses to in0 at out1, yet still masks row 2 and column 1
    drive(b(0,1) | b(2,1), b(2,2) | b(3,1), '1);
    chk("R4 pessimistic mask", gnt, b(0,1));
    chk("R3 pessimistic spec", spec, '0);
  endtask

  task automatic t_mixed();
    do_reset();
    drive(b(0,0), b(1,1) | b(2,0), '1);
    chk("R6 union", gnt, b(0,0) | b(1,1));
    chk("R7 spec subset", spec, b(1,1));
  endtask

  task automatic t_saturate();
    do_reset();
    drive('1, '1, '1);
    chk("R6 saturated one-hot", gnt, b(0,0));
    chk("R1 lowest index wins", spec, '0);
  endtask

  task automatic t_round_robin();
    do_reset();
    drive(b(0,0) | b(1,0), '0, '1);
    chk("R8 rr first", gnt, b(0,0));
    drive(b(0,0) | b(1,0), '0, '1);
    chk("R8 rr second", gnt, b(1,0));
    drive(b(0,0) | b(1,0), '0, '1);
    chk("R8 rr wrap", gnt, b(0,0));
  endtask

  task automatic t_no_update_on_drop();
    do_reset();
    drive('0, b(0,0) | b(1,0), 4'b1110);
    chk("R9 dropped winner", gnt, '0);
    drive('0, b(0,0) | b(1,0), 4'b1111);
    chk("R9 priority kept", gnt, b(0,0));
    drive('0, b(0,0) | b(1,0), 4'b1111);
    chk("R8 spec rr advances", gnt, b(1,0));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    t_reset_idle();
    t_ns_only();
    t_spec_only();
    t_vca_fail();
    t_row_mask();
    t_col_mask();
    t_pessimism();
    t_mixed();
    t_saturate();
    t_round_robin();
    t_no_update_on_drop();
    finish_run();
  end
endmodule